// File: doc/BRIEF.md
# Carry-Save Modular Multiplier

This block computes the residue of a product, `x * y mod m`, for K-bit unsigned operands. It uses two sequential stages that share one controller. The first stage is a shift-and-add multiplier. It scans `x` from its least significant bit and accumulates the partial product as a sum word plus a carry word, so no carry ripples during a step. The second stage is a reducer with a signed-digit choice in {-1, 0, +1}. It takes the double-width product and removes multiples of the modulus until a K-bit residue remains.

The product is never resolved between the two stages. When multiplication ends, the low half of the product has already been shifted out in resolved form. The high half is still a sum/carry pair. The reducer is loaded with exactly that redundant pair, widened by three guard bits so it can hold signed values. Each reduction step forms a coarse estimate from the top six bits of sum plus carry. It then adds zero, the scaled modulus or its negative in carry-save form, and shifts left. One carry-propagate addition at the end resolves the value, and a single add or subtract of `m` corrects it into range.

A caller raises `start` for one cycle while the block is idle, with `x`, `y` and `m` valid. The operands are captured on that edge. After a fixed latency, `done` pulses and `result` holds the residue until the next one.

Top module: `cs_modmul`

## Requirements
- R1: For a modulus with 2^(K-1) <= m < 2^K and operands x < m and y < m, the `result` presented with `done` equals (x*y) mod m and lies in [0, m).
- R2: `start` seen high at a clock edge while idle launches an operation. `done` is high for exactly one cycle, directly after the (2K+2)-th rising edge that follows that launch edge.
- R3: `result` changes only on the edge that raises `done` and holds its value in every other cycle.
- R4: `start` is ignored on every edge while an operation is running, including the edge that ends it. It is accepted on the edge after the final one, which is also the cycle in which `done` is high.
- R5: `x`, `y` and `m` are sampled only on the launch edge. Changing them during an operation has no effect on its result.
- R6: While `rst_n` is low, `done` and `result` are zero and the controller is idle. An operation in flight when reset is asserted produces no `done`.
- R7: A zero operand (x = 0 or y = 0) yields result 0.
- R8: The smallest legal modulus m = 2^(K-1), with x = y = m-1, and the largest operands x = y = m-1 for any legal m, produce the correct residue.
- R9: Each multiply step preserves the arithmetic: twice the new (sum + carry) plus the bit shifted into the top of the operand register equals the old sum + carry + (y AND the old lowest operand bit).
- R10: During reduction the six-bit top estimate lies in [-10, 8]. After the last step, the resolved value has its low K bits zero and its upper part lies in [-m, m].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronous to clk |
| start | input | 1 | Launch request, honoured only while idle |
| x | input | K | Multiplicand, sampled at launch |
| y | input | K | Multiplier, sampled at launch |
| m | input | K | Modulus, top bit set, sampled at launch |
| result | output | K | Residue of the latest completed operation |
| done | output | 1 | One-cycle pulse marking a new `result` |

## Verification
The range assertions on the reduction estimate and on the final resolved value assume a normalised modulus and operands strictly below it. Without those two conditions the starting value can exceed m*2^K, and the signed-digit choice cannot converge. The stimulus always draws `m` with its top bit forced to one, and draws `x` and `y` modulo `m`. Corner cases pick m-1 or zero explicitly. Operand changes in mid-flight and start requests while busy still meet these bounds, because the captured copies are the only values the datapath uses.

// File: rtl/cs_modmul_pkg.sv
package cs_modmul_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MUL  = 3'd1,
    ST_LDR  = 3'd2,
    ST_RED  = 3'd3,
    ST_FIN  = 3'd4
  } csm_state_e;

  localparam int unsigned GUARD_BITS = 3;

endpackage

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import cs_modmul_pkg::*;
#(
  parameter int unsigned K = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ld_mul,
  output logic mul_step,
  output logic ld_red,
  output logic red_step,
  output logic fin,
  output logic done
);

  localparam int unsigned CW = (K > 1) ? $clog2(K) : 1;
  localparam logic [CW-1:0] LAST = CW'(K - 1);

  csm_state_e    state_q, state_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          done_q;

  // next-state logic
  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_nx = '0;
        if (start) state_nx = ST_MUL;
      end
      ST_MUL: begin
        if (cnt_q == LAST) begin
          state_nx = ST_LDR;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      ST_LDR: state_nx = ST_RED;
      ST_RED: begin
        if (cnt_q == LAST) begin
          state_nx = ST_FIN;
          cnt_nx   = '0;
        end else begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      ST_FIN:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      done_q  <= (state_q == ST_FIN);
    end
  end

  assign ld_mul   = (state_q == ST_IDLE) && start;
  assign mul_step = (state_q == ST_MUL);
  assign ld_red   = (state_q == ST_LDR);
  assign red_step = (state_q == ST_RED);
  assign fin      = (state_q == ST_FIN);
  assign done     = done_q;

  // R2: completion flag never lasts two cycles
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: reducer is loaded only straight after the multiply phase
  p_ldr_follows_mul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MUL && cnt_q == LAST) |=> (state_q == ST_LDR));

  // R4: the final cycle always returns to idle, whatever start does
  p_fin_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIN) |=> (state_q == ST_IDLE));

  // R4: reduction cannot be restarted by start
  p_red_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RED) |=> (state_q == ST_RED || state_q == ST_FIN));

endmodule

// File: rtl/csm_mul_stage.sv
module csm_mul_stage #(
  parameter int unsigned K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  output logic [K-1:0] ps_o,
  output logic [K-1:0] pc_o,
  output logic [K-1:0] p_o
);

  logic [K-1:0] ps_q, pc_q, p_q, y_q;
  logic [K-1:0] ps_nx, pc_nx, p_nx, y_nx;
  logic [K-1:0] addend, fa_sum, fa_car;

  // one row of full adders, no carry ripple
  assign addend = y_q & {K{p_q[0]}};

  for (genvar i = 0; i < K; i++) begin : g_fa
    assign fa_sum[i] = ps_q[i] ^ pc_q[i] ^ addend[i];
    assign fa_car[i] = (ps_q[i] & pc_q[i]) | (ps_q[i] & addend[i]) |
                       (pc_q[i] & addend[i]);
  end

  always_comb begin
    ps_nx = ps_q;
    pc_nx = pc_q;
    p_nx  = p_q;
    y_nx  = y_q;
    if (load) begin
      ps_nx = '0;
      pc_nx = '0;
      p_nx  = x;
      y_nx  = y;
    end else if (step) begin
      ps_nx = {1'b0, fa_sum[K-1:1]};
      pc_nx = fa_car;
      p_nx  = {fa_sum[0], p_q[K-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
      pc_q <= '0;
      p_q  <= '0;
      y_q  <= '0;
    end else if (load || step) begin
      ps_q <= ps_nx;
      pc_q <= pc_nx;
      p_q  <= p_nx;
      y_q  <= y_nx;
    end
  end

  assign ps_o = ps_q;
  assign pc_o = pc_q;
  assign p_o  = p_q;

  // R9: each step keeps the weighted sum of the redundant accumulator
  p_csa_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=>
      (({1'b0, ps_q, 1'b0} + {1'b0, pc_q, 1'b0} + {{(K+1){1'b0}}, p_q[K-1]}) ==
       $past({2'b0, ps_q} + {2'b0, pc_q} + {2'b0, addend})));

  // R5: the captured multiplier operand holds between launches
  p_y_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(y_q));

endmodule

// File: rtl/csm_srt_stage.sv
module csm_srt_stage
  import cs_modmul_pkg::*;
#(
  parameter int unsigned K = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        step,
  input  logic [K-1:0]                ps_i,
  input  logic [K-1:0]                pc_i,
  input  logic [K-1:0]                p_i,
  input  logic [K-1:0]                m_i,
  output logic [2*K+GUARD_BITS-1:0]   sum_o,
  output logic [2*K+GUARD_BITS-1:0]   car_o
);

  localparam int unsigned W  = 2 * K + GUARD_BITS;
  localparam int unsigned LO = 2 * K - 3;
  localparam int unsigned EW = W - LO;
  localparam int unsigned PADH = W - (2 * K - 1);
  localparam logic signed [EW-1:0] EST_POS = EW'(1);
  localparam logic signed [EW-1:0] EST_NEG = EW'(-3);
  localparam logic signed [EW-1:0] EST_MAX = EW'(8);
  localparam logic signed [EW-1:0] EST_MIN = EW'(-10);

  logic [W-1:0] s_q, c_q, s_nx, c_nx;
  logic [W-1:0] m_sh, add_v, fa_sum, fa_car;
  logic signed [EW-1:0] est;
  logic         dig_pos, dig_neg;

  // coarse estimate from the top bits of both words
  assign est     = s_q[W-1:LO] + c_q[W-1:LO];
  assign dig_pos = (est >= EST_POS);
  assign dig_neg = (est <= EST_NEG);

  // modulus aligned so that K steps cover weights 2^(K-1) down to 2^0
  assign m_sh  = {{PADH{1'b0}}, m_i, {(K-1){1'b0}}};
  assign add_v = dig_pos ? ~m_sh : (dig_neg ? m_sh : '0);

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign fa_sum[i] = s_q[i] ^ c_q[i] ^ add_v[i];
    assign fa_car[i] = (s_q[i] & c_q[i]) | (s_q[i] & add_v[i]) |
                       (c_q[i] & add_v[i]);
  end

  always_comb begin
    s_nx = s_q;
    c_nx = c_q;
    if (load) begin
      s_nx = {{GUARD_BITS{1'b0}}, ps_i, p_i};
      c_nx = {{GUARD_BITS{1'b0}}, pc_i, {K{1'b0}}};
    end else if (step) begin
      // add then double; the two's complement +1 rides in the carry LSB
      s_nx = {fa_sum[W-2:0], 1'b0};
      c_nx = {fa_car[W-3:0], dig_pos, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
    end else if (load || step) begin
      s_q <= s_nx;
      c_q <= c_nx;
    end
  end

  assign sum_o = s_q;
  assign car_o = c_q;

  // R10: estimate stays inside the convergence window
  p_est_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (est <= EST_MAX && est >= EST_MIN));

  // R10: at most one digit direction per step
  p_one_digit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $onehot0({dig_pos, dig_neg}));

endmodule

// File: rtl/csm_fix.sv
module csm_fix
  import cs_modmul_pkg::*;
#(
  parameter int unsigned K = 8
) (
  input  logic [2*K+GUARD_BITS-1:0] sum_i,
  input  logic [2*K+GUARD_BITS-1:0] car_i,
  input  logic [K-1:0]              m_i,
  output logic [K+GUARD_BITS-1:0]   raw_o,
  output logic [K-1:0]              low_o,
  output logic [K-1:0]              res_o
);

  localparam int unsigned W  = 2 * K + GUARD_BITS;
  localparam int unsigned RW = K + GUARD_BITS;

  logic [W-1:0]  tot;
  logic [RW-1:0] r, mx, fixed;
  logic          neg, ovr;

  // single carry-propagate add of the redundant pair
  assign tot = sum_i + car_i;
  assign r   = tot[W-1:K];
  assign mx  = {{GUARD_BITS{1'b0}}, m_i};
  assign neg = r[RW-1];
  assign ovr = !neg && (r >= mx);

  always_comb begin
    if (neg)      fixed = r + mx;
    else if (ovr) fixed = r - mx;
    else          fixed = r;
  end

  assign raw_o = r;
  assign low_o = tot[K-1:0];
  assign res_o = fixed[K-1:0];

endmodule

// File: rtl/cs_modmul.sv
module cs_modmul
  import cs_modmul_pkg::*;
#(
  parameter int unsigned K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic [K-1:0] m,
  output logic [K-1:0] result,
  output logic         done
);

  localparam int unsigned W  = 2 * K + GUARD_BITS;
  localparam int unsigned RW = K + GUARD_BITS;

  logic ld_mul, mul_step, ld_red, red_step, fin;
  logic [K-1:0]  ps, pc, pl;
  logic [W-1:0]  rs, rc;
  logic [K-1:0]  m_q, res_c, res_q, low;
  logic [RW-1:0] raw;

  csm_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ld_mul(ld_mul), .mul_step(mul_step), .ld_red(ld_red),
    .red_step(red_step), .fin(fin), .done(done)
  );

  csm_mul_stage #(.K(K)) u_mul (
    .clk(clk), .rst_n(rst_n), .load(ld_mul), .step(mul_step),
    .x(x), .y(y), .ps_o(ps), .pc_o(pc), .p_o(pl)
  );

  csm_srt_stage #(.K(K)) u_red (
    .clk(clk), .rst_n(rst_n), .load(ld_red), .step(red_step),
    .ps_i(ps), .pc_i(pc), .p_i(pl), .m_i(m_q),
    .sum_o(rs), .car_o(rc)
  );

  csm_fix #(.K(K)) u_fix (
    .sum_i(rs), .car_i(rc), .m_i(m_q),
    .raw_o(raw), .low_o(low), .res_o(res_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q   <= '0;
      res_q <= '0;
    end else begin
      if (ld_mul) m_q   <= m;
      if (fin)    res_q <= res_c;
    end
  end

  assign result = res_q;

  logic signed [RW-1:0] raw_s, m_pos, m_neg;
  assign raw_s = raw;
  assign m_pos = {{GUARD_BITS{1'b0}}, m_q};
  assign m_neg = -m_pos;

  // R1: a delivered residue is below the captured modulus
  p_result_lt_m_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));

  // R5: the modulus copy is frozen while work is in flight
  p_m_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_step || ld_red || red_step || fin) |=> $stable(m_q));

  // R10: resolved value is an exact multiple of 2^K within [-m, m]
  p_raw_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (low == '0 && raw_s <= m_pos && raw_s >= m_neg));

  // R3: result register moves only on the completion edge
  p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(res_q));

endmodule

// File: tb/tb_cs_modmul.sv
module tb_cs_modmul;

  localparam int K   = 8;
  localparam int LAT = 2 * K + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [K-1:0] x = '0, y = '0, m = '0;
  logic [K-1:0] result;
  logic         done;

  cs_modmul #(.K(K)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x(x), .y(y), .m(m), .result(result), .done(done)
  );

  always #5 clk = ~clk;

  int     checks = 0, errors = 0, cycles = 0;
  string  tag = "R6";
  bit     finished = 0;

  // behavioural reference: remaining latency and pending residue
  int           busy_left = 0;
  logic         exp_done = 1'b0;
  logic [K-1:0] exp_res = '0;
  longint       pending = 0;

  always @(negedge rst_n) begin
    busy_left = 0;
    exp_done  = 1'b0;
    exp_res   = '0;
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      busy_left = 0;
      exp_done  = 1'b0;
      exp_res   = '0;
    end else begin
      exp_done = 1'b0;
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) begin
          exp_done = 1'b1;
          exp_res  = K'(pending);
        end
      end else if (start) begin
        busy_left = LAT;
        pending   = (longint'(x) * longint'(y)) % longint'(m);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // compare every cycle, away from the rising edge
  always begin
    @(negedge clk);
    #3;
    checks++;
    if (done !== exp_done) begin
      errors++;
      $display("FAIL R2 [%s] done=%0b expected %0b at cycle %0d", tag, done, exp_done, cycles);
    end
    checks++;
    if (result !== exp_res) begin
      errors++;
      $display("FAIL R3 [%s] result=%0d expected %0d at cycle %0d", tag, result, exp_res, cycles);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual cycles %0d expected below 150000", cycles);
      summary();
    end
  end

  task automatic launch(input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] md);
    @(negedge clk);
    x = a; y = b; m = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 1) @(negedge clk);
  endtask

  function automatic logic [K-1:0] rand_mod();
    return K'((1 << (K - 1)) | ($urandom % (1 << (K - 1))));
  endfunction

  initial begin
    logic [K-1:0] md;
    repeat (3) @(negedge clk);
    // R6: reset values are covered by the per-cycle compare while rst_n is low
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R7";
    launch('0, 8'd77, 8'd200);
    launch(8'd133, '0, 8'd151);
    launch('0, '0, 8'd128);

    tag = "R8";
    launch(8'd127, 8'd127, 8'd128);
    launch(8'd254, 8'd254, 8'd255);
    launch(8'd1, 8'd127, 8'd128);
    for (int i = 0; i < 64; i++) begin
      md = rand_mod();
      launch(md - 1'b1, md - 1'b1, md);
    end

    tag = "R1 R9 R10";
    for (int i = 0; i < 1500; i++) begin
      md = rand_mod();
      launch(K'($urandom % md), K'($urandom % md), md);
    end

    // R4: start held high through the whole run, including the final edge
    tag = "R4";
    for (int j = 0; j < 20; j++) begin
      md = rand_mod();
      @(negedge clk);
      x = K'($urandom % md); y = K'($urandom % md); m = md; start = 1'b1;
      for (int i = 1; i <= LAT; i++) begin
        @(negedge clk);
        md = rand_mod();
        x = K'($urandom % md); y = K'($urandom % md); m = md; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      repeat (LAT + 2) @(negedge clk);
    end

    // R5: operands move while busy; captured values must win
    tag = "R5";
    for (int j = 0; j < 30; j++) begin
      md = rand_mod();
      @(negedge clk);
      x = K'($urandom % md); y = K'($urandom % md); m = md; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < LAT + 1; i++) begin
        x = K'($urandom); y = K'($urandom); m = K'($urandom);
        @(negedge clk);
      end
    end

    // R6: reset in the middle of an operation, start held during reset
    tag = "R6";
    @(negedge clk);
    x = 8'd99; y = 8'd45; m = 8'd211; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (LAT + 4) @(negedge clk);
    launch(8'd99, 8'd45, 8'd211);
    repeat (4) @(negedge clk);

    summary();
  end

endmodule